// File: doc/BRIEF.md
# Serial Link Standby and Wake Controller

This block governs the low-power state of a five-wire audio codec serial link. Software shuts the link down in two steps: it first sets every sub-block powerdown bit in the powerdown field, then makes a separate write that sets the link-off bit. The block then stops the outgoing serial data and, one reference cycle later, gates off the bit clock. While the link is down it watches the frame-sync line as an asynchronous input. A high pulse that is long enough, measured in cycles of a free-running reference clock, counts as a warm-reset request. The bit clock comes back only once the sync line is seen low again, so no false frame start can be decoded.

The block can also start a wake-up from the codec side. When a pen contact is sensed during standby and pen detection is enabled, the block raises a one-cycle wake request and holds serial data-in high until the controller answers with a sync pulse. A level pen-detect flag is also provided, so that a controller without full link support can use it directly as a wake line. Setting the pen power mode to its full-off code forces that flag low and blocks any wake.

Top module: `aclink_lpwr_ctrl`

## Requirements
- R1: After reset the bit clock enable and link-active outputs are 1, the wake outputs are 0 and the stored sub-block powerdown bits are all 0.
- R2: Each write strobe stores the sub-block powerdown bits written, and they appear on the sub-block state output in the cycle after the strobe.
- R3: A link-off write (link bit 1) is ignored unless all stored sub-block bits were already 1 before it and the same write also keeps them all 1; an ignored write leaves the link active.
- R4: On an accepted link-off write, link-active falls in the cycle after the strobe, and bit clock enable falls one cycle later.
- R5: While the link is down the bit clock stays off for as long as the sync line is high; a restart begins only after the synchronized sync line reads low.
- R6: A sync high pulse that lasts fewer reference cycles than the programmed minimum width is ignored, and the link stays down.
- R7: After an accepted sync pulse, bit clock enable returns first and link-active follows exactly one cycle later; link-active is never 1 while the clock enable is 0.
- R8: The pen flag follows the pen-down input through a two-stage synchronizer (two cycles of latency) whenever the pen mode differs from the full-off code 2'b11.
- R9: A pen flag seen during standby raises wake_req for exactly one cycle and holds sdi_wake at 1 until the controller's sync pulse starts; a following qualified pulse restores the link.
- R10: With pen mode 2'b11 the pen flag stays 0 and no wake is raised, whatever the pen-down input does.
- R11: While the link is active the pen flag has no effect on the link outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_wr | input | 1 | Powerdown field write strobe |
| pd_sub_wdata | input | NSUB | Sub-block powerdown bits being written |
| pd_link_wdata | input | 1 | Link-off bit being written |
| min_pulse | input | CW | Minimum accepted sync pulse width, in reference cycles |
| sync_in | input | 1 | Frame-sync line, asynchronous while the link is down |
| pen_down | input | 1 | Raw pen contact level, asynchronous |
| pen_mode | input | 2 | Pen power mode; 2'b11 is full off |
| bitclk_en | output | 1 | Bit clock enable |
| link_active | output | 1 | Serial output and link running |
| sdi_wake | output | 1 | Drive serial data-in high for a codec-side wake |
| wake_req | output | 1 | One-cycle wake request pulse |
| pen_flag | output | 1 | Level pen-detect flag |
| pd_sub_state | output | NSUB | Stored sub-block powerdown bits |

## Verification
The bench goes after the width threshold with pulses one cycle short of the minimum and exactly at it; a design with an off-by-one counter would either wake on a runt pulse or stay asleep on a legal one. It checks that the clock stays off for the whole high phase and comes back one cycle ahead of the link; a design that restarted on the rising edge of sync would produce a false frame start. It drives link-off writes with the sub-block bits set in the same write, partly cleared, and previously cleared, where a design that skipped the two-step rule would drop the link too early. It also holds the pen down with detection switched fully off, where a design that ignored the mode would wake the link.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

    typedef enum logic [2:0] {
        LS_ACTIVE  = 3'd0,
        LS_DRAIN   = 3'd1,
        LS_DOWN    = 3'd2,
        LS_SYNC_HI = 3'd3,
        LS_WAKE    = 3'd4,
        LS_START   = 3'd5
    } link_state_e;

    localparam logic [1:0] PEN_MODE_OFF = 2'b11;

    typedef struct packed {
        logic clk_on;
        logic link_on;
        logic sdi_hi;
    } link_drive_t;

    function automatic link_drive_t drive_of(link_state_e s);
        link_drive_t d;
        d.clk_on  = (s == LS_ACTIVE) || (s == LS_DRAIN) || (s == LS_START);
        d.link_on = (s == LS_ACTIVE);
        d.sdi_hi  = (s == LS_WAKE);
        return d;
    endfunction

    function automatic logic pen_enabled(logic [1:0] mode);
        return mode != PEN_MODE_OFF;
    endfunction

endpackage

// File: rtl/lpw_sync.sv
module lpw_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= '0;
            else     chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lpw_pdreg.sv
module lpw_pdreg #(
    parameter int NSUB = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [NSUB-1:0] wsub,
    input  logic            wlink,
    input  logic            link_up,
    output logic [NSUB-1:0] sub_q,
    output logic            link_off_req
);
    // Two-step rule: the stored bits must already be all set, and this write must keep them set.
    assign link_off_req = wr && wlink && link_up && (&sub_q) && (&wsub);

    always_ff @(posedge clk) begin
        if (rst)     sub_q <= '0;
        else if (wr) sub_q <= wsub;
    end
endmodule

// File: rtl/lpw_pulse_qual.sv
module lpw_pulse_qual #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          hold,
    input  logic [CW-1:0] min_width,
    output logic          wide_enough
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                          cnt <= '0;
        else if (start)                   cnt <= CW'(1);
        else if (hold && cnt != CNT_MAX)  cnt <= cnt + CW'(1);
    end

    assign wide_enough = (cnt >= min_width);
endmodule

// File: rtl/aclink_lpwr_ctrl.sv
module aclink_lpwr_ctrl
    import lpw_pkg::*;
#(
    parameter int NSUB        = 4,
    parameter int CW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pd_wr,
    input  logic [NSUB-1:0] pd_sub_wdata,
    input  logic            pd_link_wdata,
    input  logic [CW-1:0]   min_pulse,
    input  logic            sync_in,
    input  logic            pen_down,
    input  logic [1:0]      pen_mode,
    output logic            bitclk_en,
    output logic            link_active,
    output logic            sdi_wake,
    output logic            wake_req,
    output logic            pen_flag,
    output logic [NSUB-1:0] pd_sub_state
);
    localparam int NSYNC = 2;

    link_state_e state_q, state_d;
    logic        from_wake_q, from_wake_d;
    logic        sync_s, pen_s;
    logic        link_off_req;
    logic        wide_enough;
    logic        qual_start;
    link_drive_t drv;

    lpw_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sync_in, pen_down}),
        .q   ({sync_s, pen_s})
    );

    lpw_pdreg #(.NSUB(NSUB)) u_pdreg (
        .clk          (clk),
        .rst          (rst),
        .wr           (pd_wr),
        .wsub         (pd_sub_wdata),
        .wlink        (pd_link_wdata),
        .link_up      (state_q == LS_ACTIVE),
        .sub_q        (pd_sub_state),
        .link_off_req (link_off_req)
    );

    assign qual_start = ((state_q == LS_DOWN) || (state_q == LS_WAKE)) && sync_s;

    lpw_pulse_qual #(.CW(CW)) u_qual (
        .clk         (clk),
        .rst         (rst),
        .start       (qual_start),
        .hold        ((state_q == LS_SYNC_HI) && sync_s),
        .min_width   (min_pulse),
        .wide_enough (wide_enough)
    );

    assign pen_flag = pen_s && pen_enabled(pen_mode);

    always_comb begin
        state_d     = state_q;
        from_wake_d = from_wake_q;
        unique case (state_q)
            LS_ACTIVE:  if (link_off_req) state_d = LS_DRAIN;
            LS_DRAIN:   state_d = LS_DOWN;
            LS_DOWN: begin
                if (sync_s) begin
                    state_d     = LS_SYNC_HI;
                    from_wake_d = 1'b0;
                end else if (pen_flag) begin
                    state_d = LS_WAKE;
                end
            end
            LS_WAKE: begin
                if (sync_s) begin
                    state_d     = LS_SYNC_HI;
                    from_wake_d = 1'b1;
                end
            end
            LS_SYNC_HI: begin
                if (!sync_s) begin
                    if (wide_enough)      state_d = LS_START;
                    else if (from_wake_q) state_d = LS_WAKE;
                    else                  state_d = LS_DOWN;
                end
            end
            LS_START:   state_d = LS_ACTIVE;
            default:    state_d = LS_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= LS_ACTIVE;
            from_wake_q <= 1'b0;
            wake_req    <= 1'b0;
        end else begin
            state_q     <= state_d;
            from_wake_q <= from_wake_d;
            wake_req    <= (state_q == LS_DOWN) && (state_d == LS_WAKE);
        end
    end

    assign drv         = drive_of(state_q);
    assign bitclk_en   = drv.clk_on;
    assign link_active = drv.link_on;
    assign sdi_wake    = drv.sdi_hi;
endmodule

// File: rtl/lpw_checker.sv
module lpw_checker #(
    parameter int NSUB = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            pd_wr,
    input logic [NSUB-1:0] pd_sub_wdata,
    input logic [NSUB-1:0] pd_sub_state,
    input logic            sync_s,
    input logic            bitclk_en,
    input logic            link_active,
    input logic            sdi_wake,
    input logic            wake_req,
    input logic            pen_flag
);
    AST_SUB_STORED: assert property (@(posedge clk) disable iff (rst)
        pd_wr |=> (pd_sub_state == $past(pd_sub_wdata)));               // R2
    AST_LINK_BEFORE_CLK_OFF: assert property (@(posedge clk) disable iff (rst)
        $fell(bitclk_en) |-> $past(!link_active));                      // R4
    AST_RESTART_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(bitclk_en) |-> $past(!sync_s));                           // R5
    AST_LINK_NEEDS_CLK: assert property (@(posedge clk) disable iff (rst)
        link_active |-> bitclk_en);                                     // R7
    AST_LINK_AFTER_CLK: assert property (@(posedge clk) disable iff (rst)
        $rose(link_active) |-> $past(bitclk_en));                       // R7
    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wake_req |=> !wake_req);                                        // R9
    AST_SDI_CLK_OFF: assert property (@(posedge clk) disable iff (rst)
        sdi_wake |-> !bitclk_en);                                       // R9
    AST_WAKE_FROM_PEN: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> $past(pen_flag));                                  // R10
endmodule

bind aclink_lpwr_ctrl lpw_checker #(.NSUB(NSUB)) u_lpw_chk (
    .clk          (clk),
    .rst          (rst),
    .pd_wr        (pd_wr),
    .pd_sub_wdata (pd_sub_wdata),
    .pd_sub_state (pd_sub_state),
    .sync_s       (sync_s),
    .bitclk_en    (bitclk_en),
    .link_active  (link_active),
    .sdi_wake     (sdi_wake),
    .wake_req     (wake_req),
    .pen_flag     (pen_flag)
);

// File: tb/tb_aclink_lpwr_ctrl.sv
module tb_aclink_lpwr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NSUB = 4;
    localparam int CW   = 8;
    localparam int NVEC = 7;
    // [9:6] sub bits written, [5] link bit written, [4] expected link_active, [3:0] expected stored bits
    localparam logic [9:0] VEC [NVEC] = '{
        {4'b0000, 1'b1, 1'b1, 4'b0000},
        {4'b1111, 1'b1, 1'b1, 4'b1111},
        {4'b0111, 1'b1, 1'b1, 4'b0111},
        {4'b1111, 1'b0, 1'b1, 4'b1111},
        {4'b1010, 1'b0, 1'b1, 4'b1010},
        {4'b1111, 1'b0, 1'b1, 4'b1111},
        {4'b1111, 1'b1, 1'b0, 4'b1111}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pd_wr = 1'b0;
    logic [NSUB-1:0] pd_sub_wdata = '0;
    logic pd_link_wdata = 1'b0;
    logic [CW-1:0] min_pulse = CW'(4);
    logic sync_in = 1'b0;
    logic pen_down = 1'b0;
    logic [1:0] pen_mode = 2'b00;
    logic bitclk_en, link_active, sdi_wake, wake_req, pen_flag;
    logic [NSUB-1:0] pd_sub_state;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aclink_lpwr_ctrl #(.NSUB(NSUB), .CW(CW)) dut (
        .clk(clk), .rst(rst), .pd_wr(pd_wr), .pd_sub_wdata(pd_sub_wdata),
        .pd_link_wdata(pd_link_wdata), .min_pulse(min_pulse), .sync_in(sync_in),
        .pen_down(pen_down), .pen_mode(pen_mode), .bitclk_en(bitclk_en),
        .link_active(link_active), .sdi_wake(sdi_wake), .wake_req(wake_req),
        .pen_flag(pen_flag), .pd_sub_state(pd_sub_state)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pd_write(input logic [NSUB-1:0] s, input logic l);
        @(negedge clk);
        pd_wr = 1'b1; pd_sub_wdata = s; pd_link_wdata = l;
        @(negedge clk);
        pd_wr = 1'b0; pd_link_wdata = 1'b0;
    endtask

    task automatic send_sync(input int n);
        @(negedge clk);
        sync_in = 1'b1;
        repeat (n) @(negedge clk);
        chk("R5 clock off while sync high", bitclk_en, 0);
        chk("R9 data-in released once sync answered", sdi_wake, 0);
        sync_in = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        int clk_at, link_at, pulses;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 bitclk_en", bitclk_en, 1);
        chk("R1 link_active", link_active, 1);
        chk("R1 sdi_wake", sdi_wake, 0);
        chk("R1 wake_req", wake_req, 0);
        chk("R1 sub state", pd_sub_state, 0);

        // R2 / R3 / R4: table of powerdown writes
        for (int i = 0; i < NVEC; i++) begin
            pd_write(VEC[i][9:6], VEC[i][5]);
            chk("R2 stored sub bits", pd_sub_state, VEC[i][3:0]);
            chk("R3 link gating", link_active, VEC[i][4]);
            if (!VEC[i][4]) begin
                chk("R4 clock still on after link stops", bitclk_en, 1);
                @(negedge clk);
                chk("R4 clock off one cycle later", bitclk_en, 0);
            end
        end

        // R6: runt pulse ignored
        repeat (3) @(negedge clk);
        send_sync(3);
        repeat (8) @(negedge clk);
        chk("R6 short pulse keeps clock off", bitclk_en, 0);
        chk("R6 short pulse keeps link down", link_active, 0);

        // R5 / R7: qualified pulse exactly at the minimum
        send_sync(4);
        clk_at = -1; link_at = -1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (bitclk_en && clk_at < 0) clk_at = k;
            if (link_active && link_at < 0) link_at = k;
        end
        chk("R7 link follows clock by one cycle", link_at - clk_at, 1);
        chk("R5 link restored after low", link_active, 1);

        // R9: codec-side wake from pen
        pd_write(4'b1111, 1'b1);
        repeat (3) @(negedge clk);
        pen_down = 1'b1;
        pulses = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (wake_req) pulses++;
        end
        chk("R9 single wake_req pulse", pulses, 1);
        chk("R9 sdi_wake held", sdi_wake, 1);
        chk("R9 clock off while waking", bitclk_en, 0);
        send_sync(5);
        repeat (8) @(negedge clk);
        chk("R9 link restored after answer", link_active, 1);
        chk("R9 sdi_wake cleared", sdi_wake, 0);
        pen_down = 1'b0;

        // R10: pen fully off
        pd_write(4'b1111, 1'b1);
        repeat (3) @(negedge clk);
        pen_mode = 2'b11;
        pen_down = 1'b1;
        repeat (8) @(negedge clk);
        chk("R10 pen flag forced low", pen_flag, 0);
        chk("R10 no wake drive", sdi_wake, 0);
        chk("R10 clock stays off", bitclk_en, 0);
        send_sync(4);
        repeat (8) @(negedge clk);
        chk("R10 controller wake still works", link_active, 1);
        pen_down = 1'b0;
        pen_mode = 2'b00;
        repeat (4) @(negedge clk);

        // R8 / R11: pen while active
        pen_down = 1'b1;
        @(negedge clk);
        chk("R8 flag not yet set after one cycle", pen_flag, 0);
        @(negedge clk);
        chk("R8 flag set after two cycles", pen_flag, 1);
        repeat (6) @(negedge clk);
        chk("R11 link unaffected by pen", link_active, 1);
        chk("R11 no wake pulse while active", wake_req, 0);
        pen_down = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule